// File: doc/BRIEF.md
# Segmented Stimulus/Capture Buffer Controller

This block owns one dual-port memory and divides it, at run time, into three contiguous regions. Starting at address 0 come the stimulus control words, then the stimulus data words, then the capture samples. Each region's size is loaded from a configuration strobe. The block accepts a load only if the three sizes together fit in the memory.

The two stimulus regions work as circular queues. A slow debug link streams words into them while an experiment runs. Each word carries a one-bit tag that routes it to the control queue or the data queue. A stimulus selector pops words from either queue through one read request port, and a new word is written into a slot only after the word in that slot has been read. The capture region records response samples after a trigger. Recording stops when the requested count is reached or the region is full, whichever comes first. Samples already written can be drained through a separate readout port while recording is still going on.

Memory port A serves reads, with stimulus reads taking priority over capture readout. Memory port B serves writes, with capture writes taking priority over streamed words.

Top module: `segbuf_ctrl`

## Requirements
- R1: The three regions are laid out in the order control, data, capture, starting at address 0. Their capacities are exactly the loaded sizes, and a write into one region never changes a word held in another region.
- R2: A load whose three sizes sum to more than the memory depth sets `cfg_err` and keeps the previous configuration and contents. An accepted load clears `cfg_err` and empties all three regions.
- R3: A streamed word with tag 0 goes to the control region and one with tag 1 goes to the data region. `rd_sel` uses the same encoding (0 selects control, 1 selects data). Reads return words in arrival order, with `rd_valid` and `rd_data` valid in the cycle after `rd_req`.
- R4: The control and data regions are circular. After the last slot of a region is used, writing and reading continue at the region's first slot, so arrival order is kept across the wrap.
- R5: `sin_ready` is low while the region selected by `sin_tag` is full, and a word offered then is not stored. Every read frees one slot for a new word of the same kind.
- R6: A read request to an empty region produces no `rd_valid` and sets the sticky `rd_underflow` flag. Only an accepted load clears the flag.
- R7: After `cap_trig`, each cycle with `cap_valid` high stores one sample. Recording stops after `cap_count` samples: `cap_active` falls, `cap_done` rises, `cap_fill` holds the count, and later samples are ignored.
- R8: When `cap_count` exceeds the capture region size, recording stops as soon as the region is full.
- R9: In any cycle where a capture sample is being written, `sin_ready` is low.
- R10: Each `cap_rd_req` returns the next stored sample, in order, one cycle later on `cap_rd_valid` and `cap_rd_data`, and this works while recording is still active. A request is not served when no unread sample exists or when `rd_req` is high in the same cycle.
- R11: After reset all region sizes are zero. `cfg_err`, `rd_valid`, `rd_underflow`, `cap_active`, `cap_done` and `cap_rd_valid` are low, and `sin_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the three region sizes |
| cfg_ctl_words | input | ADDR_W+1 | Control region size |
| cfg_dat_words | input | ADDR_W+1 | Data region size |
| cfg_cap_words | input | ADDR_W+1 | Capture region size |
| cfg_err | output | 1 | Last load was rejected as too large |
| sin_valid | input | 1 | Streamed word present |
| sin_tag | input | 1 | 0 = control word, 1 = data word |
| sin_word | input | DATA_W | Streamed word |
| sin_ready | output | 1 | Streamed word accepted this cycle |
| rd_req | input | 1 | Stimulus read request |
| rd_sel | input | 1 | 0 = control region, 1 = data region |
| rd_valid | output | 1 | Stimulus read data valid |
| rd_data | output | DATA_W | Stimulus read data |
| rd_underflow | output | 1 | Sticky flag: a read hit an empty region |
| cap_trig | input | 1 | Start capture |
| cap_count | input | ADDR_W+1 | Requested number of samples |
| cap_valid | input | 1 | Capture sample present |
| cap_data | input | DATA_W | Capture sample |
| cap_active | output | 1 | Capture in progress |
| cap_done | output | 1 | Capture finished |
| cap_fill | output | ADDR_W+1 | Samples stored |
| cap_rd_req | input | 1 | Capture readout request |
| cap_rd_valid | output | 1 | Capture readout data valid |
| cap_rd_data | output | DATA_W | Capture readout data |

## Verification
Streaming is first exercised with a mixed sequence of control and data tags. This shows whether words are routed by tag and whether each queue keeps its own order. Reads interleaved with refills then push both queues past their last slot, which separates correct wrap-around from pointer errors. Capture is run with a count below the region size, with a count above it, and with readout and streamed writes arriving during recording. Together these distinguish the two stop conditions and show both port priorities. Oversized and valid loads are mixed with queue contents so that a rejected load can be told apart from one that clears the regions.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  typedef enum logic {
    TAG_CTL = 1'b0,
    TAG_DAT = 1'b1
  } tag_e;
  localparam int NUM_RINGS = 2;
endpackage

// File: rtl/segbuf_mem.sv
module segbuf_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic [ADDR_W:0]   a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_en,
  input  logic [ADDR_W:0]   b_addr,
  input  logic [DATA_W-1:0] b_d
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_en) mem[b_addr[ADDR_W-1:0]] <= b_d;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr[ADDR_W-1:0]];
  end

  // R1
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    b_en |-> (b_addr[ADDR_W] == 1'b0));
  // R1
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    a_en |-> (a_addr[ADDR_W] == 1'b0));
endmodule

// File: rtl/segbuf_cfg.sv
module segbuf_cfg #(
  parameter int ADDR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ADDR_W:0] c_in,
  input  logic [ADDR_W:0] d_in,
  input  logic [ADDR_W:0] p_in,
  output logic [ADDR_W:0] c_sz,
  output logic [ADDR_W:0] d_sz,
  output logic [ADDR_W:0] p_sz,
  output logic [ADDR_W:0] d_base,
  output logic [ADDR_W:0] p_base,
  output logic            apply,
  output logic            err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SUM_W = ADDR_W + 3;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = {2'b00, c_in} + {2'b00, d_in} + {2'b00, p_in};
    apply = load && (total <= SUM_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_sz <= '0;
      d_sz <= '0;
      p_sz <= '0;
      err  <= 1'b0;
    end else if (load) begin
      err <= !apply;
      if (apply) begin
        c_sz <= c_in;
        d_sz <= d_in;
        p_sz <= p_in;
      end
    end
  end

  assign d_base = c_sz;
  assign p_base = c_sz + d_sz;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(c_sz) && $stable(d_sz) && $stable(p_sz) && $stable(err)));
endmodule

// File: rtl/segbuf_ring.sv
module segbuf_ring #(
  parameter int ADDR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic [ADDR_W:0] size,
  input  logic            push,
  input  logic            pop,
  output logic [ADDR_W:0] wr_off,
  output logic [ADDR_W:0] rd_off,
  output logic            full,
  output logic            empty
);
  localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

  logic [ADDR_W:0] count;
  logic [ADDR_W:0] last;

  assign last  = size - ONE;
  assign full  = (count == size);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (push) wr_off <= (wr_off == last) ? '0 : wr_off + ONE;
      if (pop)  rd_off <= (rd_off == last) ? '0 : rd_off + ONE;
      case ({push, pop})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= size);
  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clear) |=> (count == $past(count) + ONE));
endmodule

// File: rtl/segbuf_capture.sv
module segbuf_capture #(
  parameter int ADDR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            trig,
  input  logic [ADDR_W:0] req_cnt,
  input  logic [ADDR_W:0] size,
  input  logic            smp_valid,
  input  logic            rd_req,
  output logic            active,
  output logic            done,
  output logic [ADDR_W:0] fill,
  output logic            wr_en,
  output logic [ADDR_W:0] wr_off,
  output logic            rd_ok,
  output logic [ADDR_W:0] rd_off
);
  localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

  logic [ADDR_W:0] limit;
  logic [ADDR_W:0] lim_n;

  assign lim_n  = (req_cnt < size) ? req_cnt : size;
  assign wr_en  = active && smp_valid;
  assign wr_off = fill;
  assign rd_ok  = rd_req && (rd_off < fill);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      active <= 1'b0;
      done   <= 1'b0;
      fill   <= '0;
      limit  <= '0;
      rd_off <= '0;
    end else if (trig && !active) begin
      fill   <= '0;
      rd_off <= '0;
      limit  <= lim_n;
      active <= (lim_n != '0);
      done   <= (lim_n == '0);
    end else begin
      if (wr_en) begin
        fill <= fill + ONE;
        if (fill + ONE == limit) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
      if (rd_ok) rd_off <= rd_off + ONE;
    end
  end

  // R8
  fill_limit_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= limit);
  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> !done);
endmodule

// File: rtl/segbuf_ctrl.sv
module segbuf_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W:0]   cfg_ctl_words,
  input  logic [ADDR_W:0]   cfg_dat_words,
  input  logic [ADDR_W:0]   cfg_cap_words,
  output logic              cfg_err,
  input  logic              sin_valid,
  input  logic              sin_tag,
  input  logic [DATA_W-1:0] sin_word,
  output logic              sin_ready,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_underflow,
  input  logic              cap_trig,
  input  logic [ADDR_W:0]   cap_count,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  output logic              cap_active,
  output logic              cap_done,
  output logic [ADDR_W:0]   cap_fill,
  input  logic              cap_rd_req,
  output logic              cap_rd_valid,
  output logic [DATA_W-1:0] cap_rd_data
);
  import segbuf_pkg::*;

  localparam int NR = NUM_RINGS;

  logic [ADDR_W:0] c_sz, d_sz, p_sz, d_base, p_base;
  logic            cfg_apply;

  logic [ADDR_W:0] r_size   [NR];
  logic [ADDR_W:0] r_base   [NR];
  logic [ADDR_W:0] r_wr_off [NR];
  logic [ADDR_W:0] r_rd_off [NR];
  logic [NR-1:0]   r_full, r_empty, r_push, r_pop;

  logic            cap_we, cap_rd_ok;
  logic [ADDR_W:0] cap_wr_off, cap_rd_off;

  logic            stim_ok, sel_empty, tag_full;
  logic            a_en, b_en;
  logic [ADDR_W:0] a_addr, b_addr;
  logic [DATA_W-1:0] b_d, mem_q;

  segbuf_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .c_in(cfg_ctl_words), .d_in(cfg_dat_words), .p_in(cfg_cap_words),
    .c_sz(c_sz), .d_sz(d_sz), .p_sz(p_sz),
    .d_base(d_base), .p_base(p_base),
    .apply(cfg_apply), .err(cfg_err)
  );

  assign r_size[TAG_CTL] = c_sz;
  assign r_size[TAG_DAT] = d_sz;
  assign r_base[TAG_CTL] = '0;
  assign r_base[TAG_DAT] = d_base;

  assign sel_empty = r_empty[rd_sel];
  assign tag_full  = r_full[sin_tag];
  assign stim_ok   = rd_req && !sel_empty;
  assign sin_ready = !cap_we && !tag_full && !cfg_load;

  for (genvar g = 0; g < NR; g++) begin : g_ring
    assign r_push[g] = sin_valid && sin_ready && (sin_tag == 1'(g));
    assign r_pop[g]  = stim_ok && (rd_sel == 1'(g));
    segbuf_ring #(.ADDR_W(ADDR_W)) u_ring (
      .clk(clk), .rst(rst), .clear(cfg_apply),
      .size(r_size[g]), .push(r_push[g]), .pop(r_pop[g]),
      .wr_off(r_wr_off[g]), .rd_off(r_rd_off[g]),
      .full(r_full[g]), .empty(r_empty[g])
    );
  end

  segbuf_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .clear(cfg_apply),
    .trig(cap_trig), .req_cnt(cap_count), .size(p_sz),
    .smp_valid(cap_valid), .rd_req(cap_rd_req && !rd_req),
    .active(cap_active), .done(cap_done), .fill(cap_fill),
    .wr_en(cap_we), .wr_off(cap_wr_off),
    .rd_ok(cap_rd_ok), .rd_off(cap_rd_off)
  );

  // Port A: stimulus reads first, capture readout otherwise.
  always_comb begin
    a_en = stim_ok || cap_rd_ok;
    if (stim_ok) a_addr = r_base[rd_sel] + r_rd_off[rd_sel];
    else         a_addr = p_base + cap_rd_off;
  end

  // Port B: capture writes first, streamed words otherwise.
  always_comb begin
    b_en = cap_we || (|r_push);
    if (cap_we) begin
      b_addr = p_base + cap_wr_off;
      b_d    = cap_data;
    end else begin
      b_addr = r_base[sin_tag] + r_wr_off[sin_tag];
      b_d    = sin_word;
    end
  end

  segbuf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_addr(a_addr), .a_q(mem_q),
    .b_en(b_en), .b_addr(b_addr), .b_d(b_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      cap_rd_valid <= 1'b0;
      rd_underflow <= 1'b0;
    end else begin
      rd_valid     <= stim_ok;
      cap_rd_valid <= cap_rd_ok;
      if (cfg_apply)                 rd_underflow <= 1'b0;
      else if (rd_req && sel_empty)  rd_underflow <= 1'b1;
    end
  end

  assign rd_data     = mem_q;
  assign cap_rd_data = mem_q;

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sel_empty && !cfg_apply) |=> (!rd_valid && rd_underflow));
  // R9
  portb_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_active && cap_valid) |-> !sin_ready);
  // R10
  porta_prio_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !cap_rd_valid);
endmodule

// File: tb/segbuf_ctrl_bench.sv
`timescale 1ns/1ps
module segbuf_ctrl_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int CW = ADDR_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 0;
  logic [CW-1:0] cfg_ctl_words = 0, cfg_dat_words = 0, cfg_cap_words = 0;
  logic cfg_err;
  logic sin_valid = 0, sin_tag = 0;
  logic [DATA_W-1:0] sin_word = 0;
  logic sin_ready;
  logic rd_req = 0, rd_sel = 0;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic rd_underflow;
  logic cap_trig = 0;
  logic [CW-1:0] cap_count = 0;
  logic cap_valid = 0;
  logic [DATA_W-1:0] cap_data = 0;
  logic cap_active, cap_done;
  logic [CW-1:0] cap_fill;
  logic cap_rd_req = 0;
  logic cap_rd_valid;
  logic [DATA_W-1:0] cap_rd_data;

  int checks = 0;
  int errors = 0;
  logic last_ready;
  int c_cap, d_cap;
  logic [DATA_W-1:0] mq_c[$];
  logic [DATA_W-1:0] mq_d[$];

  always #4 clk = ~clk;

  segbuf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_segbuf_ctrl (
    .clk(clk), .rst(rst),
    .cfg_load(cfg_load), .cfg_ctl_words(cfg_ctl_words),
    .cfg_dat_words(cfg_dat_words), .cfg_cap_words(cfg_cap_words),
    .cfg_err(cfg_err),
    .sin_valid(sin_valid), .sin_tag(sin_tag), .sin_word(sin_word),
    .sin_ready(sin_ready),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_underflow(rd_underflow),
    .cap_trig(cap_trig), .cap_count(cap_count), .cap_valid(cap_valid),
    .cap_data(cap_data), .cap_active(cap_active), .cap_done(cap_done),
    .cap_fill(cap_fill),
    .cap_rd_req(cap_rd_req), .cap_rd_valid(cap_rd_valid),
    .cap_rd_data(cap_rd_data)
  );

  // {tag, word}: tag 0 = control, tag 1 = data
  localparam logic [DATA_W:0] VEC [8] = '{
    {1'b0, 16'hA001}, {1'b1, 16'hB001}, {1'b1, 16'hB002}, {1'b0, 16'hA002},
    {1'b1, 16'hB003}, {1'b0, 16'hA003}, {1'b1, 16'hB004}, {1'b0, 16'hA004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One clock cycle: drive at the falling edge, sample after the rising edge.
  task automatic cyc(input logic trig, input logic cv, input logic [DATA_W-1:0] cd,
                     input logic crd, input logic rq, input logic rs,
                     input logic sv, input logic st, input logic [DATA_W-1:0] sw);
    @(negedge clk);
    cap_trig = trig; cap_valid = cv; cap_data = cd; cap_rd_req = crd;
    rd_req = rq; rd_sel = rs; sin_valid = sv; sin_tag = st; sin_word = sw;
    #1 last_ready = sin_ready;
    @(posedge clk);
    #1;
    cap_trig = 0; cap_valid = 0; cap_rd_req = 0; rd_req = 0; sin_valid = 0;
  endtask

  task automatic cfg(input int c, input int d, input int p);
    @(negedge clk);
    cfg_load = 1; cfg_ctl_words = CW'(c); cfg_dat_words = CW'(d); cfg_cap_words = CW'(p);
    @(posedge clk);
    #1 cfg_load = 0;
  endtask

  task automatic push(input string req, input logic tag, input logic [DATA_W-1:0] w);
    logic exp_acc;
    exp_acc = tag ? (mq_d.size() < d_cap) : (mq_c.size() < c_cap);
    cyc(0, 0, 0, 0, 0, 0, 1, tag, w);
    chk(req, 32'(last_ready), 32'(exp_acc));
    if (last_ready) begin
      if (tag) mq_d.push_back(w); else mq_c.push_back(w);
    end
  endtask

  task automatic pop(input string req, input logic sel);
    logic [DATA_W-1:0] e;
    logic has;
    has = sel ? (mq_d.size() > 0) : (mq_c.size() > 0);
    cyc(0, 0, 0, 0, 1, sel, 0, 0, 0);
    chk(req, 32'(rd_valid), 32'(has));
    if (has) begin
      e = sel ? mq_d.pop_front() : mq_c.pop_front();
      chk(req, 32'(rd_data), 32'(e));
    end else begin
      chk(req, 32'(rd_underflow), 32'd1);
    end
  endtask

  task automatic cap_read(input string req, input logic exp_v, input logic [DATA_W-1:0] e);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(req, 32'(cap_rd_valid), 32'(exp_v));
    if (exp_v) chk(req, 32'(cap_rd_data), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    c_cap = 0; d_cap = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 cfg_err", 32'(cfg_err), 0);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    chk("R11 rd_underflow", 32'(rd_underflow), 0);
    chk("R11 cap_active", 32'(cap_active), 0);
    chk("R11 cap_done", 32'(cap_done), 0);
    chk("R11 cap_rd_valid", 32'(cap_rd_valid), 0);
    @(negedge clk) rst = 0;
    push("R11 sin_ready with zero sizes", 1'b0, 16'h0BAD);

    cfg(4, 6, 8); c_cap = 4; d_cap = 6;
    chk("R2 accepted load", 32'(cfg_err), 0);

    // R3 table of mixed-tag words
    for (int i = 0; i < 8; i++) push("R3 table push", VEC[i][DATA_W], VEC[i][DATA_W-1:0]);
    push("R5 control full refuses", 1'b0, 16'hA005);
    pop("R3 control order", 1'b0);
    pop("R3 control order", 1'b0);
    push("R5 freed slot accepts", 1'b0, 16'hA005);
    push("R5 freed slot accepts", 1'b0, 16'hA006);
    for (int i = 0; i < 4; i++) pop("R4 control wrap order", 1'b0);
    pop("R6 control empty read", 1'b0);
    push("R5 data fill", 1'b1, 16'hB005);
    push("R5 data fill", 1'b1, 16'hB006);
    push("R5 data full refuses", 1'b1, 16'hB007);
    for (int i = 0; i < 3; i++) pop("R3 data order", 1'b1);
    for (int i = 0; i < 3; i++) push("R4 data refill", 1'b1, DATA_W'(16'hB010 + i));
    for (int i = 0; i < 6; i++) pop("R4 data wrap order", 1'b1);
    pop("R6 data empty read", 1'b1);

    // R2 rejected load keeps contents and flag
    push("R2 data before bad load", 1'b1, 16'hB100);
    cfg(10, 10, 13);
    chk("R2 oversize load sets cfg_err", 32'(cfg_err), 1);
    chk("R6 underflow stays sticky", 32'(rd_underflow), 1);
    pop("R2 contents kept after rejected load", 1'b1);
    push("R2 size kept after rejected load", 1'b0, 16'hA100);
    pop("R2 size kept after rejected load", 1'b0);
    push("R2 data before good load", 1'b1, 16'hB101);
    cfg(4, 6, 8);
    mq_d.delete(); mq_c.delete();
    chk("R2 good load clears cfg_err", 32'(cfg_err), 0);
    chk("R6 good load clears underflow", 32'(rd_underflow), 0);
    pop("R2 good load empties data", 1'b1);

    // R1 fill all three regions, then read back
    for (int i = 0; i < 5; i++) push("R1 control capacity", 1'b0, DATA_W'(16'hC000 + i));
    for (int i = 0; i < 7; i++) push("R1 data capacity", 1'b1, DATA_W'(16'hD000 + i));
    cap_count = CW'(20);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 trigger starts capture", 32'(cap_active), 1);
    for (int i = 0; i < 10; i++) cyc(0, 1, DATA_W'(16'hE000 + i), 0, 0, 0, 0, 0, 0);
    chk("R8 stop at region full fill", 32'(cap_fill), 8);
    chk("R8 stop at region full done", 32'(cap_done), 1);
    chk("R8 stop at region full active", 32'(cap_active), 0);
    for (int i = 0; i < 4; i++) pop("R1 control intact", 1'b0);
    for (int i = 0; i < 6; i++) pop("R1 data intact", 1'b1);
    for (int i = 0; i < 8; i++) cap_read("R10 readout order", 1'b1, DATA_W'(16'hE000 + i));
    cap_read("R10 readout past fill", 1'b0, 0);

    // R7, R9, R10 count-limited capture with concurrent traffic
    cap_count = CW'(5);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'hF000, 0, 0, 0, 1, 1'b0, 16'hA200);
    chk("R9 capture write blocks stream", 32'(last_ready), 0);
    push("R9 stream accepted between samples", 1'b0, 16'hA201);
    cyc(0, 1, 16'hF001, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'hF002, 1, 0, 0, 0, 0, 0);
    chk("R10 readout during capture valid", 32'(cap_rd_valid), 1);
    chk("R10 readout during capture data", 32'(cap_rd_data), 32'hF000);
    chk("R10 capture still active", 32'(cap_active), 1);
    cyc(0, 1, 16'hF003, 1, 1, 1'b0, 0, 0, 0);
    chk("R10 stimulus read wins port A", 32'(rd_valid), 1);
    chk("R10 stimulus read data", 32'(rd_data), 32'hA201);
    chk("R10 readout refused on conflict", 32'(cap_rd_valid), 0);
    void'(mq_c.pop_front());
    cyc(0, 1, 16'hF004, 0, 0, 0, 0, 0, 0);
    chk("R7 count reached done", 32'(cap_done), 1);
    chk("R7 count reached active", 32'(cap_active), 0);
    cyc(0, 1, 16'hF005, 0, 0, 0, 0, 0, 0);
    chk("R7 later samples ignored", 32'(cap_fill), 5);
    for (int i = 1; i < 5; i++) cap_read("R10 readout resumes in order", 1'b1, DATA_W'(16'hF000 + i));
    cap_read("R10 readout exhausted", 1'b0, 0);

    finish_run();
  end
endmodule